// File: doc/BRIEF.md
# NAND Host-to-Flash Bus Bridge

This block joins a 16-bit host register port to an 8-bit NAND flash bus. The host sees a small register window. A mode byte sets the flash control pins directly. A data port moves bytes to and from the flash. A status byte reports whether the flash is busy. Every host access to the data port becomes one byte cycle, or two byte cycles for a 16-bit access. Each byte cycle holds the write or read strobe low for a set number of clocks and then high for the same number.

The host starts an access by raising `h_req` together with the direction, the size, the offset and the write data. It keeps these steady until `h_done` pulses for one clock. Register accesses finish on the clock after they are taken. Data accesses finish only when their last byte cycle is over. The flash ready/busy line passes through a synchroniser before the status byte reports it.

Top module: `nand_bus_bridge`

## Requirements
- R1: While reset is asserted and directly after it, the mode byte is 0x00. The pins then read: `nf_cle`=0, `nf_ale`=0, `nf_ce_n`=1, `nf_pwr`=0, `nf_wp_n`=0, `nf_we_n`=1, `nf_re_n`=1, `nf_io_oe`=0. `h_done` is 0.
- R2: The mode byte sits at offset 0x04 and reads back in `h_rdata[7:0]`, with the upper bits zero. The pins follow it as follows. Bit 0 drives `nf_cle`. Bit 1 drives `nf_ale`. Bit 4 set drives `nf_ce_n` low. Bits 3:2 drive `nf_pwr[1:0]`. Bit 7 drives `nf_wp_n`. So 0x94 gives a data cycle setup, 0x95 adds command latch and 0x96 adds address latch. 0x00 gives standby with the chip deselected. 0x0C gives `nf_pwr`=11 (power on) and 0x08 gives `nf_pwr`=10 (power off).
- R3: `nf_cle`, `nf_ale`, `nf_ce_n`, `nf_pwr` and `nf_wp_n` stay unchanged from the start of a data access until it completes. A mode write is taken only when no byte cycle is running.
- R4: A 16-bit write to offset 0x00 sends `h_wdata[7:0]` first and `h_wdata[15:8]` second. In each byte cycle `nf_we_n` is low for STROBE_CLKS clocks and then high for STROBE_CLKS clocks, with `nf_io_oe` high and the byte on `nf_io_out`.
- R5: A 16-bit read of offset 0x00 runs two cycles on `nf_re_n`, each low for STROBE_CLKS clocks and then high for STROBE_CLKS clocks. The byte on `nf_io_in` is sampled in the last low clock. The first byte is returned in `h_rdata[7:0]` and the second in `h_rdata[15:8]`.
- R6: An 8-bit access to offset 0x00 (`h_wide`=0) runs exactly one byte cycle. A write sends `h_wdata[7:0]`. A read returns the byte zero-extended to 16 bits.
- R7: The status byte at offset 0x05 returns `h_rdata[7]`=1 while the flash is busy (`nf_rb_n` low) and 0 when it is ready. All other bits are 0. A change on `nf_rb_n` shows up in a read accepted two clock edges after the change has been sampled. A read accepted one edge after it still shows the old value.
- R8: Offsets 0x06, 0x07 and the unused offsets 0x01 to 0x03 read as zero. Writes to them have no effect on the mode byte or the pins.
- R9: `h_done` is a one-clock pulse. It rises one clock after a register access is taken. For a data access it rises 2·STROBE_CLKS·B + 1 clocks after the request is first driven, where B is the number of byte cycles.
- R10: `nf_we_n` and `nf_re_n` are never low together. `nf_io_oe` is low whenever `nf_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_req | input | 1 | Host access request, held until `h_done` |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| h_addr | input | 3 | Register byte offset |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid with `h_done` |
| h_done | output | 1 | Access complete pulse |
| nf_io_in | input | 8 | Byte from the flash bus |
| nf_io_out | output | 8 | Byte to the flash bus |
| nf_io_oe | output | 1 | Drive enable for the flash data bus |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write permit level from mode bit 7 |
| nf_pwr | output | 2 | Card power control from mode bits 3:2 |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0), asynchronous |

## Verification
Two events can land in the same short window: a change on the asynchronous ready/busy line, and the acceptance of a status read. The bench moves `nf_rb_n` at a set number of clocks before it issues a status read. With one sampled edge between the change and the acceptance, the old level must come back. With two sampled edges, the new level must come back, in both the busy and the ready direction. A reference model runs alongside on every clock. It checks the strobe waveform, the byte order on the flash bus and the completion time, and it compares every control pin against the mode byte the model expects.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_LOW  = 2'd1,
      ENG_HIGH = 2'd2
   } eng_state_t;

   // register byte offsets
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_MODE = 3'd4;
   localparam logic [2:0] OFS_STAT = 3'd5;

   // mode byte field positions
   localparam int MODE_CLE_BIT = 0;
   localparam int MODE_ALE_BIT = 1;
   localparam int MODE_PWR_LSB = 2;
   localparam int MODE_CE_BIT  = 4;
   localparam int MODE_WP_BIT  = 7;
   localparam int STAT_BSY_BIT = 7;

   typedef struct packed {
      logic       cle;
      logic       ale;
      logic       ce_n;
      logic [1:0] pwr;
      logic       wp_n;
   } nf_ctl_t;

endpackage

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("nbb_rb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/nbb_mode_reg.sv
module nbb_mode_reg
   import nbb_pkg::*;
#(
   parameter int MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_val,
   output logic [MODE_W-1:0] mode,
   output nf_ctl_t           ctl
);

   if (MODE_W < 8) begin : g_bad_width
      $error("nbb_mode_reg: MODE_W must cover bits 0 to 7");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode <= '0;
      else if (wr_en) mode <= wr_val;
   end

   always_comb begin
      ctl.cle  = mode[MODE_CLE_BIT];
      ctl.ale  = mode[MODE_ALE_BIT];
      ctl.ce_n = ~mode[MODE_CE_BIT];
      ctl.pwr  = mode[MODE_PWR_LSB +: 2];
      ctl.wp_n = mode[MODE_WP_BIT];
   end

endmodule

// File: rtl/nbb_byte_engine.sv
module nbb_byte_engine
   import nbb_pkg::*;
#(
   parameter int NAND_W      = 8,
   parameter int HOST_W      = 16,
   parameter int STROBE_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_mode,
   input  logic              wide,
   input  logic [HOST_W-1:0] wr_word,
   input  logic [NAND_W-1:0] io_in,
   output logic              busy,
   output logic              fin,
   output logic [HOST_W-1:0] rd_word,
   output logic [NAND_W-1:0] io_out,
   output logic              io_oe,
   output logic              we_n,
   output logic              re_n
);

   localparam int BEATS = HOST_W / NAND_W;
   localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int CW    = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
   localparam logic [CW-1:0] CNT_LAST  = CW'(STROBE_CLKS - 1);
   localparam logic [BW-1:0] BEAT_LAST = BW'(BEATS - 1);

   if (STROBE_CLKS < 1) begin : g_bad_strobe
      $error("nbb_byte_engine: STROBE_CLKS must be at least 1");
   end
   if (HOST_W % NAND_W != 0 || BEATS < 1) begin : g_bad_ratio
      $error("nbb_byte_engine: HOST_W must be a multiple of NAND_W");
   end

   eng_state_t        state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     beat;
   logic [BW-1:0]     last_beat;
   logic              rd_q;
   logic [HOST_W-1:0] wbuf;
   logic [HOST_W-1:0] rbuf;
   logic              fin_q;
   logic              cnt_end;
   logic              take;

   assign cnt_end = (cnt == CNT_LAST);
   assign take    = (state == ENG_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ENG_IDLE;
         cnt       <= '0;
         beat      <= '0;
         last_beat <= '0;
         rd_q      <= 1'b0;
         wbuf      <= '0;
         fin_q     <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         unique case (state)
            ENG_IDLE: begin
               if (start) begin
                  state     <= ENG_LOW;
                  cnt       <= '0;
                  beat      <= '0;
                  last_beat <= wide ? BEAT_LAST : '0;
                  rd_q      <= rd_mode;
                  wbuf      <= wr_word;
               end
            end
            ENG_LOW: begin
               if (cnt_end) begin
                  cnt   <= '0;
                  state <= ENG_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ENG_HIGH: begin
               if (cnt_end) begin
                  cnt <= '0;
                  if (beat == last_beat) begin
                     state <= ENG_IDLE;
                     fin_q <= 1'b1;
                  end else begin
                     beat  <= beat + 1'b1;
                     state <= ENG_LOW;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   // one capture lane per byte position of the host word
   for (genvar i = 0; i < BEATS; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbuf[i*NAND_W +: NAND_W] <= '0;
         else if (take)
            rbuf[i*NAND_W +: NAND_W] <= '0;
         else if (state == ENG_LOW && cnt_end && rd_q && beat == BW'(i))
            rbuf[i*NAND_W +: NAND_W] <= io_in;
      end
   end

   assign busy    = (state != ENG_IDLE);
   assign fin     = fin_q;
   assign rd_word = rbuf;
   assign io_out  = wbuf[beat*NAND_W +: NAND_W];
   assign io_oe   = busy && !rd_q;
   assign we_n    = !((state == ENG_LOW) && !rd_q);
   assign re_n    = !((state == ENG_LOW) && rd_q);

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
   import nbb_pkg::*;
#(
   parameter int HOST_W      = 16,
   parameter int NAND_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int STROBE_CLKS = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_wr,
   input  logic              h_wide,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [HOST_W-1:0] h_wdata,
   output logic [HOST_W-1:0] h_rdata,
   output logic              h_done,
   input  logic [NAND_W-1:0] nf_io_in,
   output logic [NAND_W-1:0] nf_io_out,
   output logic              nf_io_oe,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic              nf_wp_n,
   output logic [1:0]        nf_pwr,
   input  logic              nf_rb_n
);

   localparam int MODE_W = 8;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("nand_bus_bridge: ADDR_W must reach offset 7");
   end
   if (HOST_W < MODE_W) begin : g_bad_host
      $error("nand_bus_bridge: HOST_W must hold the mode byte");
   end

   logic              rb_sync;
   logic              eng_busy;
   logic              eng_fin;
   logic [HOST_W-1:0] eng_rdata;
   logic [MODE_W-1:0] mode;
   nf_ctl_t           ctl;
   logic              accept;
   logic              hit_data;
   logic              hit_mode;
   logic              hit_stat;
   logic              reg_acc;
   logic              reg_done;
   logic [HOST_W-1:0] reg_rdata;
   logic              src_eng;

   assign hit_data = (h_addr == ADDR_W'(OFS_DATA));
   assign hit_mode = (h_addr == ADDR_W'(OFS_MODE));
   assign hit_stat = (h_addr == ADDR_W'(OFS_STAT));
   assign accept   = h_req && !eng_busy && !h_done;
   assign reg_acc  = accept && !hit_data;

   nbb_rb_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_rb_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(nf_rb_n),
      .q_sync (rb_sync)
   );

   nbb_mode_reg #(
      .MODE_W(MODE_W)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_acc && h_wr && hit_mode),
      .wr_val(h_wdata[MODE_W-1:0]),
      .mode  (mode),
      .ctl   (ctl)
   );

   nbb_byte_engine #(
      .NAND_W     (NAND_W),
      .HOST_W     (HOST_W),
      .STROBE_CLKS(STROBE_CLKS)
   ) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept && hit_data),
      .rd_mode(!h_wr),
      .wide   (h_wide),
      .wr_word(h_wdata),
      .io_in  (nf_io_in),
      .busy   (eng_busy),
      .fin    (eng_fin),
      .rd_word(eng_rdata),
      .io_out (nf_io_out),
      .io_oe  (nf_io_oe),
      .we_n   (nf_we_n),
      .re_n   (nf_re_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_done  <= 1'b0;
         reg_rdata <= '0;
         src_eng   <= 1'b0;
      end else begin
         reg_done <= reg_acc;
         if (accept) src_eng <= hit_data;
         if (reg_acc) begin
            reg_rdata <= '0;
            if (!h_wr && hit_mode)
               reg_rdata <= HOST_W'(mode);
            else if (!h_wr && hit_stat)
               reg_rdata <= HOST_W'(!rb_sync) << STAT_BSY_BIT;
         end
      end
   end

   assign h_done  = reg_done | eng_fin;
   assign h_rdata = src_eng ? eng_rdata : reg_rdata;

   assign nf_cle  = ctl.cle;
   assign nf_ale  = ctl.ale;
   assign nf_ce_n = ctl.ce_n;
   assign nf_pwr  = ctl.pwr;
   assign nf_wp_n = ctl.wp_n;

endmodule

// File: rtl/nbb_checker.sv
module nbb_checker #(
   parameter int STROBE_CLKS = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       h_done,
   input logic       nf_we_n,
   input logic       nf_re_n,
   input logic       nf_io_oe,
   input logic       nf_cle,
   input logic       nf_ale,
   input logic       nf_ce_n,
   input logic [1:0] nf_pwr,
   input logic       nf_wp_n
);

   logic [15:0] we_run;
   logic [15:0] re_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run <= '0;
         re_run <= '0;
      end else begin
         we_run <= nf_we_n ? 16'd0 : we_run + 16'd1;
         re_run <= nf_re_n ? 16'd0 : re_run + 16'd1;
      end
   end

   a_r3_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |=> $stable({nf_cle, nf_ale, nf_ce_n, nf_pwr, nf_wp_n}));

   a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nf_we_n) |-> (we_run == 16'(STROBE_CLKS)));

   a_r4_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_we_n |-> nf_io_oe);

   a_r5_re_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nf_re_n) |-> (re_run == 16'(STROBE_CLKS)));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      h_done |=> !h_done);

   a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!nf_we_n, !nf_re_n}));

   a_r10_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_io_oe);

endmodule

bind nand_bus_bridge nbb_checker #(
   .STROBE_CLKS(STROBE_CLKS)
) u_nbb_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .h_done  (h_done),
   .nf_we_n (nf_we_n),
   .nf_re_n (nf_re_n),
   .nf_io_oe(nf_io_oe),
   .nf_cle  (nf_cle),
   .nf_ale  (nf_ale),
   .nf_ce_n (nf_ce_n),
   .nf_pwr  (nf_pwr),
   .nf_wp_n (nf_wp_n)
);

// File: tb/test_nand_bus_bridge.sv
module test_nand_bus_bridge;

   localparam int N = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0;
   logic        h_wr = 1'b0;
   logic        h_wide = 1'b0;
   logic [2:0]  h_addr = '0;
   logic [15:0] h_wdata = '0;
   logic [15:0] h_rdata;
   logic        h_done;
   logic [7:0]  nf_io_in = '0;
   logic [7:0]  nf_io_out;
   logic        nf_io_oe;
   logic        nf_ce_n;
   logic        nf_cle;
   logic        nf_ale;
   logic        nf_we_n;
   logic        nf_re_n;
   logic        nf_wp_n;
   logic [1:0]  nf_pwr;
   logic        nf_rb_n = 1'b1;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // model state
   logic [7:0]  exp_mode = 8'h00;
   logic        cur_wr = 1'b0;
   logic [2:0]  cur_addr = '0;
   logic [15:0] cur_wd = '0;

   always #10 clk = ~clk;

   nand_bus_bridge #(.STROBE_CLKS(N)) i_nand_bus_bridge (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_wide(h_wide),
      .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_done(h_done),
      .nf_io_in(nf_io_in), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
      .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
      .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n), .nf_pwr(nf_pwr), .nf_rb_n(nf_rb_n)
   );

   task automatic chk(input bit ok, input string msg, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", msg, act, exp);
      end
   endtask

   // per-clock model comparison of the control pins
   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      if (rst_n) begin
         if (h_done && cur_wr && cur_addr == 3'd4) exp_mode = cur_wd[7:0];
         chk(nf_cle === exp_mode[0], "R2 cle", {15'd0, nf_cle}, {15'd0, exp_mode[0]});
         chk(nf_ale === exp_mode[1], "R2 ale", {15'd0, nf_ale}, {15'd0, exp_mode[1]});
         chk(nf_ce_n === !exp_mode[4], "R2 ce_n", {15'd0, nf_ce_n}, {15'd0, !exp_mode[4]});
         chk(nf_pwr === exp_mode[3:2], "R2 pwr", {14'd0, nf_pwr}, {14'd0, exp_mode[3:2]});
         chk(nf_wp_n === exp_mode[7], "R2 wp_n", {15'd0, nf_wp_n}, {15'd0, exp_mode[7]});
         chk(!(nf_we_n === 1'b0 && nf_re_n === 1'b0), "R10 both strobes", {14'd0, nf_we_n, nf_re_n}, 16'h3);
         if (nf_re_n === 1'b0)
            chk(nf_io_oe === 1'b0, "R10 drive during read", {15'd0, nf_io_oe}, 16'd0);
      end
   end

   task automatic xfer(input bit wr, input bit wide, input logic [2:0] addr,
                       input logic [15:0] wd, input logic [15:0] rin,
                       output logic [15:0] rd, input string tag);
      int  beats = wide ? 2 : 1;
      bit  data  = (addr == 3'd0);
      int  exp_k = data ? 2 * N * beats + 1 : 1;
      int  k = 0;
      @(negedge clk);
      cur_wr = wr; cur_addr = addr; cur_wd = wd;
      h_req = 1'b1; h_wr = wr; h_wide = wide; h_addr = addr; h_wdata = wd;
      nf_io_in = rin[7:0];
      forever begin
         @(negedge clk);
         k++;
         if (data && k < exp_k) begin
            int  ph = (k - 1) % (2 * N);
            int  b  = (k - 1) / (2 * N);
            bit  lo = (ph < N);
            chk(nf_we_n === !(lo && wr), {tag, " we_n waveform"}, {15'd0, nf_we_n}, {15'd0, !(lo && wr)});
            chk(nf_re_n === !(lo && !wr), {tag, " re_n waveform"}, {15'd0, nf_re_n}, {15'd0, !(lo && !wr)});
            chk(nf_io_oe === wr, {tag, " bus drive"}, {15'd0, nf_io_oe}, {15'd0, wr});
            if (wr && lo)
               chk(nf_io_out === wd[b*8 +: 8], {tag, " byte order"}, {8'd0, nf_io_out}, {8'd0, wd[b*8 +: 8]});
            if (k == N + 1) nf_io_in = rin[15:8];
         end
         if (h_done === 1'b1 || k >= 200) break;
      end
      h_req = 1'b0;
      rd = h_rdata;
      chk(k == exp_k, {tag, " R9 completion clock"}, 16'(k), 16'(exp_k));
      @(negedge clk);
      chk(h_done === 1'b0, {tag, " R9 single pulse"}, {15'd0, h_done}, 16'd0);
   endtask

   task automatic stat_probe(input logic newrb, input int extra, input logic [15:0] exp, input string tag);
      logic [15:0] r;
      @(negedge clk);
      nf_rb_n = newrb;
      repeat (extra) @(negedge clk);
      xfer(1'b0, 1'b0, 3'd5, 16'h0, 16'h0, r, tag);
      chk(r === exp, {tag, " status value"}, r, exp);
   endtask

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({nf_cle, nf_ale, nf_ce_n, nf_pwr, nf_wp_n} === 6'b001000, "R1 control pins in reset",
          {10'd0, nf_cle, nf_ale, nf_ce_n, nf_pwr, nf_wp_n}, 16'h0008);
      chk({nf_we_n, nf_re_n, nf_io_oe, h_done} === 4'b1100, "R1 strobes in reset",
          {12'd0, nf_we_n, nf_re_n, nf_io_oe, h_done}, 16'h000c);
      rst_n = 1'b1;
      @(negedge clk);
      chk({nf_we_n, nf_re_n, nf_ce_n} === 3'b111, "R1 after release", {13'd0, nf_we_n, nf_re_n, nf_ce_n}, 16'h7);

      // R2 mode readback and power codes
      xfer(1'b0, 1'b0, 3'd4, 16'h0, 16'h0, r, "R2");
      chk(r === 16'h0000, "R2 mode after reset", r, 16'h0000);
      xfer(1'b1, 1'b0, 3'd4, 16'hFF0C, 16'h0, r, "R2");
      chk(nf_pwr === 2'b11, "R2 power on", {14'd0, nf_pwr}, 16'h3);
      xfer(1'b0, 1'b0, 3'd4, 16'h0, 16'h0, r, "R2");
      chk(r === 16'h000C, "R2 mode readback upper zero", r, 16'h000C);

      // R6 command byte in command mode, R3 pins steady
      xfer(1'b1, 1'b0, 3'd4, 16'h0095, 16'h0, r, "R2");
      chk({nf_cle, nf_ale, nf_ce_n} === 3'b100, "R2 command setup", {13'd0, nf_cle, nf_ale, nf_ce_n}, 16'h4);
      xfer(1'b1, 1'b0, 3'd0, 16'hAAFF, 16'h0, r, "R6");
      chk(nf_cle === 1'b1, "R3 cle held", {15'd0, nf_cle}, 16'h1);

      // address mode, two single bytes
      xfer(1'b1, 1'b0, 3'd4, 16'h0096, 16'h0, r, "R2");
      chk({nf_cle, nf_ale} === 2'b01, "R2 address setup", {14'd0, nf_cle, nf_ale}, 16'h1);
      xfer(1'b1, 1'b0, 3'd0, 16'h0000, 16'h0, r, "R6");
      xfer(1'b1, 1'b0, 3'd0, 16'h0012, 16'h0, r, "R6");

      // data mode, wide write and read
      xfer(1'b1, 1'b0, 3'd4, 16'h0094, 16'h0, r, "R2");
      xfer(1'b1, 1'b1, 3'd0, 16'hA55A, 16'h0, r, "R4");
      xfer(1'b1, 1'b1, 3'd0, 16'h0180, 16'h0, r, "R4");
      xfer(1'b0, 1'b1, 3'd0, 16'h0, 16'hC33C, r, "R5");
      chk(r === 16'hC33C, "R5 byte packing", r, 16'hC33C);
      xfer(1'b0, 1'b1, 3'd0, 16'h0, 16'h12FE, r, "R5");
      chk(r === 16'h12FE, "R5 byte packing second", r, 16'h12FE);
      xfer(1'b0, 1'b0, 3'd0, 16'h0, 16'h9977, r, "R6");
      chk(r === 16'h0077, "R6 narrow read zero-extended", r, 16'h0077);

      // R7 status and synchroniser latency
      xfer(1'b0, 1'b0, 3'd5, 16'h0, 16'h0, r, "R7");
      chk(r === 16'h0000, "R7 ready", r, 16'h0000);
      stat_probe(1'b0, 0, 16'h0000, "R7 busy one edge");
      xfer(1'b0, 1'b0, 3'd5, 16'h0, 16'h0, r, "R7");
      chk(r === 16'h0080, "R7 busy settled", r, 16'h0080);
      stat_probe(1'b1, 0, 16'h0080, "R7 ready one edge");
      stat_probe(1'b0, 3, 16'h0080, "R7 busy later");
      stat_probe(1'b1, 1, 16'h0000, "R7 ready two edges");

      // R8 unused and interrupt offsets
      xfer(1'b1, 1'b0, 3'd6, 16'hFFFF, 16'h0, r, "R8");
      xfer(1'b1, 1'b0, 3'd7, 16'hFFFF, 16'h0, r, "R8");
      xfer(1'b1, 1'b0, 3'd3, 16'h00FF, 16'h0, r, "R8");
      xfer(1'b0, 1'b0, 3'd6, 16'h0, 16'h0, r, "R8");
      chk(r === 16'h0000, "R8 offset 6 reads zero", r, 16'h0000);
      xfer(1'b0, 1'b0, 3'd7, 16'h0, 16'h0, r, "R8");
      chk(r === 16'h0000, "R8 offset 7 reads zero", r, 16'h0000);
      xfer(1'b0, 1'b0, 3'd2, 16'h0, 16'h0, r, "R8");
      chk(r === 16'h0000, "R8 offset 2 reads zero", r, 16'h0000);
      xfer(1'b0, 1'b0, 3'd4, 16'h0, 16'h0, r, "R8");
      chk(r === 16'h0094, "R8 mode untouched", r, 16'h0094);

      // power off and standby codes
      xfer(1'b1, 1'b0, 3'd4, 16'h0008, 16'h0, r, "R2");
      chk(nf_pwr === 2'b10, "R2 power off", {14'd0, nf_pwr}, 16'h2);
      xfer(1'b1, 1'b0, 3'd4, 16'h0000, 16'h0, r, "R2");
      chk(nf_ce_n === 1'b1, "R2 standby deselect", {15'd0, nf_ce_n}, 16'h1);

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule